// File: doc/BRIEF.md
# Target Bus Master Access Engine

This block borrows the memory bus of a small 8-bit processor so that a host can read and write that processor's memory directly. On a command it pulls an active-low bus request and waits for the processor's active-low grant. Only after the grant does it drive a 19-bit address. It then runs memory cycles with active-low memory-enable, read and write strobes on an 8-bit data bus. The data bus is split into a data-out word, a data-in word and an output enable, so that the pad ring can build the bidirectional pins.

Four operations are offered: a single-byte read, a single-byte write, a block write that takes a new byte from the host for each address, and a fill that writes one constant byte to a run of addresses. Block writes and fills turn on the data drivers once and keep memory-enable low for the whole run. When the run ends the engine gives the bus back in a fixed order: data drivers off, address drivers off, request released, then a wait for the grant to go away. An optional timeout gives up when the grant never arrives.

Top module: `xbus_master`

## Requirements
- R1: While reset is held, and afterwards until a command starts, bus_req_no, mem_en_no, rd_no and wr_no are high, addr_oe_o and data_oe_o are low, and busy_o, done_o, blk_take_o and timeout_o are low.
- R2: A pulse on cmd_start_i while idle pulls bus_req_no low from the next cycle. The engine stays in request for as long as bus_grant_ni reads high. In the cycle after it first samples the grant low it raises addr_oe_o with the command address, and memory-enable falls one cycle later.
- R3: Release takes three cycles in this order: data_oe_o falls, then addr_oe_o falls, then bus_req_no rises. bus_req_no stays high until bus_grant_ni is sampled high. In the next cycle busy_o falls and done_o is high for exactly one cycle.
- R4: A single write (cmd_op_i = 1) runs one cycle with the data driven and write still high, WR_W cycles with wr_no low, and one cycle with wr_no high again. Memory-enable then rises one cycle before the release begins.
- R5: A single read (cmd_op_i = 0) keeps data_oe_o low and holds rd_no low for RD_W cycles (RD_W of at least 2). It samples data_i in the last of those cycles and shows the sampled byte on rd_data_o from the cycle in which done_o is high. The strobe then rises one cycle before memory-enable.
- R6: A block write (cmd_op_i = 2) writes cmd_len_i bytes to rising addresses, wrapping from the top of the 19-bit space to zero. The first byte is cmd_data_i at start. Every further byte is loaded from cmd_data_i at the end of a cycle in which blk_take_o is high. The next address appears one cycle before its data. Memory-enable and data_oe_o stay active across the whole run.
- R7: A fill (cmd_op_i = 3) writes the byte given at start to cmd_len_i rising addresses with the same timing as a block write, and never raises blk_take_o.
- R8: A block write or fill with a length of 0 or 1 writes exactly one byte.
- R9: cmd_start_i while busy_o is high has no effect on the running command's pin sequence, and no later cycle is run for it.
- R10: When the grant has not been sampled low within TO_CYC request cycles, the engine drives no address, releases the request, raises timeout_o and finishes with done_o. A grant sampled in the last allowed cycle is still taken. timeout_o stays high until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_start_i | input | 1 | Start pulse for a command, taken only while idle |
| cmd_op_i | input | 2 | 0 read, 1 write, 2 block write, 3 fill |
| cmd_addr_i | input | ADDR_W | Start address |
| cmd_data_i | input | DATA_W | Write or fill byte; next block byte when blk_take_o is high |
| cmd_len_i | input | LEN_W | Byte count for block write and fill |
| busy_o | output | 1 | High from accepted start until the bus is released |
| done_o | output | 1 | One-cycle pulse at command end |
| blk_take_o | output | 1 | Block write loads the next byte from cmd_data_i this cycle |
| rd_data_o | output | DATA_W | Byte captured by the last read |
| timeout_o | output | 1 | Grant did not arrive in time for the last command |
| bus_req_no | output | 1 | Bus request, active low |
| bus_grant_ni | input | 1 | Bus grant, active low |
| addr_o | output | ADDR_W | Address value |
| addr_oe_o | output | 1 | Address driver enable |
| data_o | output | DATA_W | Data bus output value |
| data_oe_o | output | 1 | Data driver enable |
| data_i | input | DATA_W | Data bus input value |
| mem_en_no | output | 1 | Memory enable, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |

## Verification
The engine is driven with grants that arrive after one cycle and after several cycles, and with grant releases that are quick or slow. These patterns separate a correct handshake wait from one that assumes a fixed latency. Writes are followed by reads of the same address, so the bytes that reach the modelled memory through the strobes must come back on rd_data_o; an untouched address returns a pattern computed from its value. Block writes across the top of the address space, fills, one-byte runs, a start issued mid-command, a grant that never arrives and one that arrives in the last allowed cycle each bring out a different ordering or boundary.

// File: rtl/xbm_pkg.sv
package xbm_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_BLOCK = 2'd2,
    OP_FILL  = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_REQ, ST_ADDR, ST_MEN,
    ST_WDAT, ST_WSTB, ST_WEND, ST_NEXT,
    ST_RSTB, ST_RCAP, ST_REND, ST_MOFF,
    ST_RELD, ST_RELA, ST_RELR
  } st_e;
endpackage

// File: rtl/xbm_cnt.sv
module xbm_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (clr_i)           cnt_o <= '0;
    else if (cnt_o != '1)     cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/xbm_pins.sv
module xbm_pins
  import xbm_pkg::*;
(
  input  st_e  state_i,
  input  logic is_wr_i,
  output logic req_no,
  output logic addr_oe_o,
  output logic data_oe_o,
  output logic men_no,
  output logic rd_no,
  output logic wr_no
);
  always_comb begin
    req_no    = (state_i == ST_IDLE) || (state_i == ST_RELR);
    addr_oe_o = state_i inside {ST_ADDR, ST_MEN, ST_WDAT, ST_WSTB, ST_WEND, ST_NEXT,
                                ST_RSTB, ST_RCAP, ST_REND, ST_MOFF, ST_RELD};
    data_oe_o = is_wr_i && (state_i inside {ST_WDAT, ST_WSTB, ST_WEND, ST_NEXT, ST_MOFF});
    men_no    = !(state_i inside {ST_MEN, ST_WDAT, ST_WSTB, ST_WEND, ST_NEXT,
                                  ST_RSTB, ST_RCAP, ST_REND});
    rd_no     = !(state_i inside {ST_RSTB, ST_RCAP});
    wr_no     = (state_i != ST_WSTB);
  end
endmodule

// File: rtl/xbm_ctrl.sv
module xbm_ctrl
  import xbm_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 16,
  parameter int WR_W   = 1,
  parameter int RD_W   = 2,
  parameter int TO_CYC = 64,
  parameter int CNT_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              grant_ni,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              cnt_clr_o,
  output st_e               state_o,
  output logic              is_wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              timeout_o,
  output logic              done_o,
  output logic              take_o
);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_W - 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_W - 2);
  localparam logic [CNT_W-1:0] TO_LAST = CNT_W'((TO_CYC > 0) ? TO_CYC - 1 : 0);

  st_e              state_q, state_d;
  op_e              op_q;
  logic [LEN_W-1:0] left_q;
  logic             multi;

  assign multi = (op_i == OP_BLOCK) || (op_i == OP_FILL);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_REQ;
      ST_REQ: begin
        if (!grant_ni)                          state_d = ST_ADDR;
        else if (TO_CYC > 0 && cnt_i == TO_LAST) state_d = ST_RELR;
      end
      ST_ADDR: state_d = ST_MEN;
      ST_MEN:  state_d = (op_q == OP_READ) ? ST_RSTB : ST_WDAT;
      ST_WDAT: state_d = ST_WSTB;
      ST_WSTB: if (cnt_i == WR_LAST) state_d = ST_WEND;
      ST_WEND: state_d = (left_q != '0) ? ST_NEXT : ST_MOFF;
      ST_NEXT: state_d = ST_WDAT;
      ST_RSTB: if (cnt_i == RD_LAST) state_d = ST_RCAP;
      ST_RCAP: state_d = ST_REND;
      ST_REND: state_d = ST_MOFF;
      ST_MOFF: state_d = ST_RELD;
      ST_RELD: state_d = ST_RELA;
      ST_RELA: state_d = ST_RELR;
      ST_RELR: if (grant_ni) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_READ;
      left_q    <= '0;
      addr_o    <= '0;
      wdata_o   <= '0;
      rd_data_o <= '0;
      timeout_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= (state_q == ST_RELR) && (state_d == ST_IDLE);
      if (state_q == ST_IDLE && start_i) begin
        op_q      <= op_i;
        addr_o    <= addr_i;
        wdata_o   <= wdata_i;
        left_q    <= (multi && len_i > LEN_W'(1)) ? len_i - LEN_W'(1) : '0;
        timeout_o <= 1'b0;
      end
      if (state_q == ST_REQ && state_d == ST_RELR) timeout_o <= 1'b1;
      // next address is presented one cycle ahead of its data
      if (state_q == ST_WEND && state_d == ST_NEXT) begin
        addr_o <= addr_o + 1'b1;
        left_q <= left_q - 1'b1;
      end
      if (take_o)                rd_data_o <= rd_data_o;
      if (take_o)                wdata_o   <= wdata_i;
      if (state_q == ST_RCAP)    rd_data_o <= bus_data_i;
    end
  end

  assign take_o    = (state_q == ST_NEXT) && (op_q == OP_BLOCK);
  assign cnt_clr_o = (state_d != state_q);
  assign state_o   = state_q;
  assign is_wr_o   = (op_q != OP_READ);
endmodule

// File: rtl/xbus_master.sv
module xbus_master
  import xbm_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 16,
  parameter int WR_W   = 1,
  parameter int RD_W   = 2,
  parameter int TO_CYC = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_start_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              blk_take_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              timeout_o,
  output logic              bus_req_no,
  input  logic              bus_grant_ni,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [DATA_W-1:0] data_i,
  output logic              mem_en_no,
  output logic              rd_no,
  output logic              wr_no
);
  localparam int MAX_A = (TO_CYC > WR_W) ? TO_CYC : WR_W;
  localparam int MAX_C = (MAX_A > RD_W) ? MAX_A : RD_W;
  localparam int CNT_W = $clog2(MAX_C + 1);

  st_e              state;
  logic             is_wr;
  logic             cnt_clr;
  logic [CNT_W-1:0] cnt;

  xbm_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .cnt_o  (cnt)
  );

  xbm_ctrl #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .LEN_W (LEN_W),
    .WR_W   (WR_W),   .RD_W   (RD_W),   .TO_CYC (TO_CYC), .CNT_W (CNT_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (cmd_start_i),
    .op_i       (op_e'(cmd_op_i)),
    .addr_i     (cmd_addr_i),
    .wdata_i    (cmd_data_i),
    .len_i      (cmd_len_i),
    .grant_ni   (bus_grant_ni),
    .bus_data_i (data_i),
    .cnt_i      (cnt),
    .cnt_clr_o  (cnt_clr),
    .state_o    (state),
    .is_wr_o    (is_wr),
    .addr_o     (addr_o),
    .wdata_o    (data_o),
    .rd_data_o  (rd_data_o),
    .timeout_o  (timeout_o),
    .done_o     (done_o),
    .take_o     (blk_take_o)
  );

  xbm_pins u_pins (
    .state_i   (state),
    .is_wr_i   (is_wr),
    .req_no    (bus_req_no),
    .addr_oe_o (addr_oe_o),
    .data_oe_o (data_oe_o),
    .men_no    (mem_en_no),
    .rd_no     (rd_no),
    .wr_no     (wr_no)
  );

  assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/xbm_checker.sv
module xbm_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic blk_take_o,
  input logic timeout_o,
  input logic bus_req_no,
  input logic bus_grant_ni,
  input logic addr_oe_o,
  input logic data_oe_o,
  input logic mem_en_no,
  input logic rd_no,
  input logic wr_no
);
  // R2: address only after a sampled grant, with the request held
  a_r2_addr_after_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_oe_o) |-> ($past(!bus_grant_ni) && !bus_req_no));

  // R3: address floats only once data is already floated
  a_r3_addr_after_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(addr_oe_o) |-> (!data_oe_o && $past(!data_oe_o)));

  // R3: request released with all drivers off
  a_r3_req_after_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_no) |-> (!addr_oe_o && !data_oe_o && $past(!addr_oe_o)));

  a_r3_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r4_write_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> (data_oe_o && !mem_en_no && addr_oe_o && rd_no));

  a_r5_read_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> (!data_oe_o && !mem_en_no && addr_oe_o && wr_no));

  a_r5_read_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_no) |-> ($past(!rd_no) && $past(!rd_no, 2)));

  a_r6_take_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_take_o |-> (!mem_en_no && data_oe_o && wr_no));

  a_r10_timeout_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> (!addr_oe_o && bus_req_no));
endmodule

bind xbus_master xbm_checker u_chk (.*);

// File: tb/xbus_master_tb.sv
`timescale 1ns/1ps
module xbus_master_tb;
  localparam int WRW = 1;
  localparam int RDW = 2;
  localparam int TOC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [18:0] cmd_addr = '0;
  logic [7:0]  cmd_data = '0;
  logic [15:0] cmd_len = '0;
  logic        grant_n = 1'b1;
  logic [7:0]  din = '0;
  logic        busy_o, done_o, take_o, timeout_o, bus_req_no, addr_oe_o, data_oe_o;
  logic        mem_en_no, rd_no, wr_no;
  logic [7:0]  rd_data_o, data_o;
  logic [18:0] addr_o;

  always #2 clk = ~clk;

  xbus_master #(.TO_CYC(TOC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_start_i(start), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .cmd_len_i(cmd_len),
    .busy_o(busy_o), .done_o(done_o), .blk_take_o(take_o), .rd_data_o(rd_data_o),
    .timeout_o(timeout_o), .bus_req_no(bus_req_no), .bus_grant_ni(grant_n),
    .addr_o(addr_o), .addr_oe_o(addr_oe_o), .data_o(data_o), .data_oe_o(data_oe_o),
    .data_i(din), .mem_en_no(mem_en_no), .rd_no(rd_no), .wr_no(wr_no)
  );

  typedef struct packed {
    logic req, aoe, doe, men, rd, wr, busy, done, take;
    logic [18:0] addr;
    logic [7:0]  data;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] dev_mem[int];
  logic [7:0] ref_mem[int];
  logic [7:0] blk[$];
  int checks = 0, errors = 0;
  int gd = 1, gr = 1, lo_cnt = 0, hi_cnt = 0, bidx = 0;
  bit adv = 0, blk_mode = 0;
  logic prev_wr = 1'b1;

  function automatic logic [7:0] pat(logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h96;
  endfunction

  function automatic logic [7:0] dev_rd(logic [18:0] a);
    if (dev_mem.exists(int'(a))) return dev_mem[int'(a)];
    return pat(a);
  endfunction

  function automatic logic [7:0] ref_rd(logic [18:0] a);
    if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
    return pat(a);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: memory device, grant responder and block byte feeder
  task automatic tick();
    @(negedge clk);
    if (wr_no && !prev_wr && !mem_en_no && data_oe_o) dev_mem[int'(addr_o)] = data_o;
    prev_wr = wr_no;
    din = !rd_no ? dev_rd(addr_o) : 8'h00;
    if (!bus_req_no) begin
      lo_cnt++; hi_cnt = 0;
      if (lo_cnt >= gd) grant_n = 1'b0;
    end else begin
      hi_cnt++; lo_cnt = 0;
      if (hi_cnt >= gr) grant_n = 1'b1;
    end
    if (blk_mode) begin
      if (adv) begin
        if (bidx + 1 < blk.size()) begin bidx++; cmd_data = blk[bidx]; end
        adv = 0;
      end
      if (take_o) adv = 1;
    end
  endtask

  function automatic void put(logic req, aoe, doe, men, rd, wr, busy, done, take,
                              logic [18:0] a, logic [7:0] d);
    exp_t e;
    e.req = req; e.aoe = aoe; e.doe = doe; e.men = men; e.rd = rd; e.wr = wr;
    e.busy = busy; e.done = done; e.take = take;
    e.addr = aoe ? a : '0;
    e.data = doe ? d : '0;
    exp_q.push_back(e);
  endfunction

  task automatic run_cmd(string tag, logic [1:0] op, logic [18:0] a, logic [7:0] d,
                         int len, int g_d, int g_r, int ign_at);
    bit to;
    int n;
    logic [18:0] ca;
    logic [7:0]  cd, exp_rd;
    exp_t e, act;
    to = (g_d > TOC);
    n  = (op >= 2) ? ((len < 1) ? 1 : len) : 1;
    exp_rd = ref_rd(a);
    ca = a;
    for (int i = 0; i < (to ? TOC : g_d); i++) put(0,0,0,1,1,1,1,0,0,ca,0);
    if (!to) begin
      put(0,1,0,1,1,1,1,0,0,ca,0);
      put(0,1,0,0,1,1,1,0,0,ca,0);
      if (op == 2'd0) begin
        for (int i = 0; i < RDW; i++) put(0,1,0,0,0,1,1,0,0,ca,0);
        put(0,1,0,0,1,1,1,0,0,ca,0);
        put(0,1,0,1,1,1,1,0,0,ca,0);
      end else begin
        for (int i = 0; i < n; i++) begin
          cd = (op == 2'd2) ? blk[i] : d;
          ref_mem[int'(ca)] = cd;
          put(0,1,1,0,1,1,1,0,0,ca,cd);
          for (int w = 0; w < WRW; w++) put(0,1,1,0,1,0,1,0,0,ca,cd);
          put(0,1,1,0,1,1,1,0,0,ca,cd);
          if (i < n - 1) begin
            ca = ca + 1'b1;
            put(0,1,1,0,1,1,1,0,(op == 2'd2),ca,cd);
          end
        end
        put(0,1,1,1,1,1,1,0,0,ca,cd);
      end
      put(0,1,0,1,1,1,1,0,0,ca,0);
      put(0,0,0,1,1,1,1,0,0,ca,0);
      for (int i = 0; i < g_r; i++) put(1,0,0,1,1,1,1,0,0,ca,0);
    end else begin
      put(1,0,0,1,1,1,1,0,0,ca,0);
    end
    put(1,0,0,1,1,1,0,1,0,ca,0);

    gd = g_d; gr = g_r;
    tick();
    cmd_op = op; cmd_addr = a; cmd_len = 16'(len);
    blk_mode = (op == 2'd2); bidx = 0; adv = blk_mode;
    cmd_data = blk_mode ? blk[0] : d;
    start = 1'b1;
    for (int k = 0; exp_q.size() > 0; k++) begin
      e = exp_q.pop_front();
      tick();
      if (k == 0 || (ign_at >= 0 && k == ign_at + 1)) start = 1'b0;
      act.req = bus_req_no; act.aoe = addr_oe_o; act.doe = data_oe_o; act.men = mem_en_no;
      act.rd = rd_no; act.wr = wr_no; act.busy = busy_o; act.done = done_o; act.take = take_o;
      act.addr = e.aoe ? addr_o : '0;
      act.data = e.doe ? data_o : '0;
      chk($sformatf("%s cycle %0d", tag, k), 64'(act), 64'(e));
      if (ign_at >= 0 && k == ign_at) begin
        start = 1'b1; cmd_op = 2'd1; cmd_addr = 19'h00400; cmd_data = 8'hEE;
      end
    end
    blk_mode = 0;
    if (op == 2'd0 && !to) chk({tag, " R5 rd_data"}, 64'(rd_data_o), 64'(exp_rd));
    chk({tag, " R10 timeout flag"}, 64'(timeout_o), 64'(to));
  endtask

  task automatic chk_idle(string tag);
    chk(tag, {58'b0, bus_req_no, mem_en_no, rd_no, wr_no, addr_oe_o, data_oe_o},
        64'b111100);
    chk({tag, " status"}, {60'b0, busy_o, done_o, take_o, timeout_o}, 64'b0);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (2) tick();
    chk_idle("R1 after reset");

    // R2 R3 R4: single write, fast grant
    run_cmd("R4 write", 2'd1, 19'h12345, 8'hA5, 0, 1, 1, -1);
    // R5: read back, slow grant and slow release (R2, R3)
    run_cmd("R5 read back", 2'd0, 19'h12345, 8'h00, 0, 3, 2, -1);
    run_cmd("R5 read untouched", 2'd0, 19'h00100, 8'h00, 0, 2, 3, -1);

    // R6: block write across the top of the address space
    blk = '{8'h11, 8'h22, 8'h33, 8'h44};
    run_cmd("R6 block wrap", 2'd2, 19'h7FFFE, 8'h00, 4, 1, 1, -1);
    run_cmd("R6 read 7FFFF", 2'd0, 19'h7FFFF, 8'h00, 0, 1, 1, -1);
    run_cmd("R6 read 00001", 2'd0, 19'h00001, 8'h00, 0, 1, 1, -1);

    // R7: fill
    run_cmd("R7 fill", 2'd3, 19'h00200, 8'h3C, 3, 2, 1, -1);
    run_cmd("R7 read 202", 2'd0, 19'h00202, 8'h00, 0, 1, 1, -1);
    run_cmd("R7 read 203", 2'd0, 19'h00203, 8'h00, 0, 1, 1, -1);

    // R8: one-byte runs
    blk = '{8'h5A};
    run_cmd("R8 block len0", 2'd2, 19'h00300, 8'h00, 0, 1, 1, -1);
    run_cmd("R8 fill len1", 2'd3, 19'h00310, 8'h77, 1, 1, 1, -1);
    run_cmd("R8 read 301", 2'd0, 19'h00301, 8'h00, 0, 1, 1, -1);
    run_cmd("R8 read 311", 2'd0, 19'h00311, 8'h00, 0, 1, 1, -1);

    // R9: start while busy
    run_cmd("R9 ignored start", 2'd1, 19'h00600, 8'h99, 0, 2, 1, 4);
    run_cmd("R9 read 400", 2'd0, 19'h00400, 8'h00, 0, 1, 1, -1);

    // R10: no grant, then grant in the last allowed cycle
    run_cmd("R10 timeout", 2'd0, 19'h00500, 8'h00, 0, 1000, 1, -1);
    tick();
    chk("R10 flag held", 64'(timeout_o), 64'd1);
    run_cmd("R10 last-cycle grant", 2'd1, 19'h00510, 8'h42, 0, TOC, 1, -1);
    run_cmd("R10 read 510", 2'd0, 19'h00510, 8'h00, 0, 1, 2, -1);
    tick();
    chk_idle("R1 idle at end");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule